// File: doc/BRIEF.md
# Converter Slot Sequencer

This block drives a single shared analog-to-digital converter through a pass of four sampling slots. A pass begins when the compute engine signals the start of a new program pass. For each slot, the block sets the analog mux select and waits for the next slow-clock tick, which runs at 32.768 kHz. On that tick it pulses a conversion start. When the decimation filter returns its done strobe, the block writes the sample into a working-memory word. The address of that word is set by the channel the slot selected.

The processor can ask for an alternate pass. This is normally done rarely, about once a second. The request is held until the next pass begins. That one pass then uses a second slot map, which puts the die temperature and the digital supply in place of the two voltage-sensor slots. The request clears itself when that pass ends, and a status bit records that the alternate pass has completed. The block includes a time-out for each slot. If the filter never answers, the slot is skipped and an error flag is raised, so the pass does not stall.

Top module: `adc_slot_sequencer`

## Requirements
- R1: After reset, busy, conv_start, wr_en, err and alt_done are 0, and mux_sel is 0.
- R2: A pass is accepted only on a one-cycle pass_start while the block is idle. A pass_start that arrives during a pass has no effect, so that pass still issues exactly four conversions, and no further pass follows it.
- R3: In a normal pass, slots 0, 1, 2 and 3 drive mux_sel with the codes 0 (A0), 1 (A1), 2 (A2) and 3 (A3), in that order.
- R4: In an alternate pass, slots 0, 1, 2 and 3 drive mux_sel with the codes 4 (temperature), 1 (A1), 5 (digital supply) and 3 (A3), in that order.
- R5: conv_start is a one-cycle pulse. It is issued only in the cycle after a tick has been sampled, and it is issued exactly once per slot.
- R6: A filt_done during a slot's wait writes filt_data one cycle later. Codes 0 to 3 go to SAMPLE_BASE plus the code. Code 4 goes to AUX_BASE, and code 5 goes to AUX_BASE+1.
- R7: A filt_done that arrives while no slot is waiting causes no write.
- R8: An alt_req is held until the next pass is accepted, and it applies to that pass only. A request made during a normal pass applies to the pass after it. The request is cleared when the alternate pass ends.
- R9: alt_done is set when an alternate pass ends. It is cleared when the next pass is accepted.
- R10: If no filt_done arrives within TIMEOUT_TICKS ticks after a conversion start, the slot is skipped without a write. In that case err is set, and it stays set until the next pass is accepted.
- R11: busy is high from the cycle after a pass is accepted through the cycle in which the last sample is written. wr_en and conv_start occur only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at the 32.768 kHz sample rate |
| pass_start | input | 1 | Compute engine begins a new program pass |
| alt_req | input | 1 | Processor request for one alternate pass |
| filt_done | input | 1 | Filter result ready strobe |
| filt_data | input | DATA_W | Filter result |
| mux_sel | output | 3 | Analog channel code for the current slot |
| conv_start | output | 1 | Conversion start pulse |
| wr_en | output | 1 | Working-memory write strobe |
| wr_addr | output | ADDR_W | Working-memory word address |
| wr_data | output | DATA_W | Sample written |
| busy | output | 1 | Pass in progress |
| alt_done | output | 1 | The last alternate pass has finished |
| err | output | 1 | A slot timed out in the current or last pass |

## Verification
The checker watches the local timing on every cycle:
- conv_start is a single-cycle pulse that follows a tick;
- writes happen only one cycle after a filter strobe and inside a pass;
- a pass begins only on a request;
- err and alt_done stay set between passes.

Some behaviour can only be shown by the bench's scenarios. These are the slot order of each map, the address each sample lands at, a pending alternate request carrying over to the next pass, and a skipped slot leaving its word untouched. Stray strobes and start requests made during a pass are also covered by these scenarios.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    typedef enum logic [2:0] {
        CH_A0   = 3'd0,
        CH_A1   = 3'd1,
        CH_A2   = 3'd2,
        CH_A3   = 3'd3,
        CH_TEMP = 3'd4,
        CH_VSUP = 3'd5
    } chan_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

endpackage

// File: rtl/slot_seq_map.sv
module slot_seq_map
    import slot_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned SLOT_W      = 2,
    parameter int unsigned SAMPLE_BASE = 32,
    parameter int unsigned AUX_BASE    = 40
) (
    input  logic              alt,
    input  logic [SLOT_W-1:0] slot,
    output chan_e             chan,
    output logic [ADDR_W-1:0] addr
);

    // The slot order is behaviour: the alternate map keeps the current slots.
    always_comb begin
        case (slot[1:0])
            2'd0:    chan = alt ? CH_TEMP : CH_A0;
            2'd1:    chan = CH_A1;
            2'd2:    chan = alt ? CH_VSUP : CH_A2;
            default: chan = CH_A3;
        endcase
    end

    // Sensor channels share a bank; auxiliary readings use a bank of their own.
    always_comb begin
        if (chan[2])
            addr = ADDR_W'(AUX_BASE) + ADDR_W'(chan[0]);
        else
            addr = ADDR_W'(SAMPLE_BASE) + ADDR_W'(chan[1:0]);
    end

endmodule

// File: rtl/slot_seq_timeout.sv
module slot_seq_timeout #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expired = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == CNT_W'(LIMIT - 1))
                expired = 1'b1;
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer
    import slot_seq_pkg::*;
#(
    parameter int unsigned DATA_W        = 22,
    parameter int unsigned ADDR_W        = 7,
    parameter int unsigned N_SLOTS       = 4,
    parameter int unsigned SAMPLE_BASE   = 32,
    parameter int unsigned AUX_BASE      = 40,
    parameter int unsigned TIMEOUT_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pass_start,
    input  logic              alt_req,
    input  logic              filt_done,
    input  logic [DATA_W-1:0] filt_data,
    output logic [2:0]        mux_sel,
    output logic              conv_start,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              alt_done,
    output logic              err
);

    localparam int unsigned SLOT_W = $clog2(N_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [SLOT_W-1:0] slot;
        logic              alt_mode;
        logic              alt_pend;
        logic              alt_done;
        logic              err;
        logic              conv_start;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } regs_t;

    regs_t d, q;

    chan_e             cur_chan;
    logic [ADDR_W-1:0] cur_addr;
    logic              slot_expired;
    logic              slot_finish;

    slot_seq_map #(
        .ADDR_W      (ADDR_W),
        .SLOT_W      (SLOT_W),
        .SAMPLE_BASE (SAMPLE_BASE),
        .AUX_BASE    (AUX_BASE)
    ) u_map (
        .alt  (q.alt_mode),
        .slot (q.slot),
        .chan (cur_chan),
        .addr (cur_addr)
    );

    slot_seq_timeout #(
        .LIMIT (TIMEOUT_TICKS)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.phase == PH_WAIT),
        .tick    (tick),
        .expired (slot_expired)
    );

    always_comb begin
        d            = q;
        d.conv_start = 1'b0;
        d.wr_en      = 1'b0;
        slot_finish  = 1'b0;
        if (alt_req)
            d.alt_pend = 1'b1;

        case (q.phase)
            PH_IDLE: begin
                if (pass_start) begin
                    d.phase    = PH_ARM;
                    d.slot     = '0;
                    d.alt_mode = q.alt_pend;
                    d.alt_done = 1'b0;
                    d.err      = 1'b0;
                end
            end
            PH_ARM: begin
                if (tick) begin
                    d.conv_start = 1'b1;
                    d.phase      = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (filt_done) begin
                    d.wr_en     = 1'b1;
                    d.wr_addr   = cur_addr;
                    d.wr_data   = filt_data;
                    slot_finish = 1'b1;
                end else if (slot_expired) begin
                    d.err       = 1'b1;
                    slot_finish = 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase

        if (slot_finish) begin
            if (q.slot == LAST_SLOT) begin
                d.phase = PH_IDLE;
                if (q.alt_mode) begin
                    d.alt_done = 1'b1;
                    d.alt_pend = alt_req;
                end
            end else begin
                d.slot  = q.slot + 1'b1;
                d.phase = PH_ARM;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase      <= PH_IDLE;
            q.slot       <= '0;
            q.alt_mode   <= 1'b0;
            q.alt_pend   <= 1'b0;
            q.alt_done   <= 1'b0;
            q.err        <= 1'b0;
            q.conv_start <= 1'b0;
            q.wr_en      <= 1'b0;
            q.wr_addr    <= '0;
            q.wr_data    <= '0;
        end else begin
            q <= d;
        end
    end

    assign mux_sel    = cur_chan;
    assign conv_start = q.conv_start;
    assign wr_en      = q.wr_en;
    assign wr_addr    = q.wr_addr;
    assign wr_data    = q.wr_data;
    assign busy       = (q.phase != PH_IDLE) || q.wr_en;
    assign alt_done   = q.alt_done;
    assign err        = q.err;

endmodule

// File: rtl/adc_slot_sequencer_chk.sv
module adc_slot_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       pass_start,
    input logic       filt_done,
    input logic [2:0] mux_sel,
    input logic       conv_start,
    input logic       wr_en,
    input logic       busy,
    input logic       alt_done,
    input logic       err
);

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_start_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(tick));

    assert_start_in_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    assert_write_in_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    assert_pass_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pass_start));

    assert_write_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(filt_done));

    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (mux_sel <= 3'd5));

    assert_err_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !pass_start) |=> err);

    assert_alt_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_done && !pass_start) |=> alt_done);

endmodule

bind adc_slot_sequencer adc_slot_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pass_start (pass_start),
    .filt_done  (filt_done),
    .mux_sel    (mux_sel),
    .conv_start (conv_start),
    .wr_en      (wr_en),
    .busy       (busy),
    .alt_done   (alt_done),
    .err        (err)
);

// File: tb/adc_slot_sequencer_test.sv
module adc_slot_sequencer_test;

    localparam int DW        = 22;
    localparam int AW        = 7;
    localparam int SBASE     = 32;
    localparam int ABASE     = 40;
    localparam int TMO       = 4;
    localparam int CONV_CLKS = 8;
    localparam int MEM_N     = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          pass_start = 1'b0;
    logic          alt_req = 1'b0;
    logic          conv_done = 1'b0;
    logic          stray_done = 1'b0;
    logic [DW-1:0] filt_data = '0;
    logic          filt_done;
    logic [2:0]    mux_sel;
    logic          conv_start, wr_en, busy, alt_done, err;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    assign filt_done = conv_done | stray_done;

    always #2 clk = ~clk;

    adc_slot_sequencer #(
        .DATA_W (DW), .ADDR_W (AW), .N_SLOTS (4),
        .SAMPLE_BASE (SBASE), .AUX_BASE (ABASE), .TIMEOUT_TICKS (TMO)
    ) uut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .pass_start (pass_start),
        .alt_req (alt_req), .filt_done (filt_done), .filt_data (filt_data),
        .mux_sel (mux_sel), .conv_start (conv_start), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data), .busy (busy),
        .alt_done (alt_done), .err (err)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Written only by the monitor / converter model below.
    int            cs_cnt = 0;
    int            wr_cnt = 0;
    int            tick_miss = 0;
    logic [2:0]    seen_sel [64];
    logic [DW-1:0] mem      [MEM_N];
    logic [DW-1:0] exp_mem  [MEM_N];
    int            tdiv = 0;
    bit            cv_busy = 1'b0;
    int            cv_cnt = 0;
    logic [2:0]    cv_sel = '0;

    // Written only by the stimulus process.
    int pass_base = 0;
    int drop_slot = -1;

    function automatic int exp_chan(bit alt, int s);
        if (!alt) return s;
        case (s)
            0: return 4;
            2: return 5;
            default: return s;
        endcase
    endfunction

    function automatic int exp_addr(int ch);
        if (ch < 4) return SBASE + ch;
        return ABASE + ch - 4;
    endfunction

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            mem[i] = '0;
            exp_mem[i] = '0;
        end
        for (int i = 0; i < 64; i++) seen_sel[i] = '0;
    end

    // Tick source, converter/filter model and port monitor, all on the falling edge.
    always @(negedge clk) begin
        logic [DW-1:0] v;
        tick      <= (tdiv == 3);
        tdiv      <= (tdiv + 1) % 4;
        conv_done <= 1'b0;
        if (conv_start) begin
            if (!tick) tick_miss++;
            seen_sel[cs_cnt & 63] = mux_sel;
            cv_busy <= ((cs_cnt - pass_base) != drop_slot);
            cv_cnt  <= CONV_CLKS;
            cv_sel  <= mux_sel;
            cs_cnt++;
        end else if (cv_busy) begin
            if (cv_cnt == 1) begin
                v = DW'($urandom);
                filt_data <= v;
                conv_done <= 1'b1;
                exp_mem[exp_addr(int'(cv_sel))] = v;
                cv_busy <= 1'b0;
            end else begin
                cv_cnt <= cv_cnt - 1;
            end
        end
        if (wr_en) begin
            mem[wr_addr] = wr_data;
            wr_cnt++;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wait_idle(output bit ok);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        ok = !busy;
    endtask

    task automatic compare_mem(string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MEM_N; i++)
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        check(bad == 0, req, "memory words differing (first addr shown as count)", bad, 0);
    endtask

    // One pass: optional mid-pass pass_start (R2) and mid-pass alt_req (R8).
    task automatic run_pass(bit exp_alt, int drop, bit mid_start, bit mid_alt);
        int  wbase;
        bit  ok;
        int  nwr;
        @(negedge clk);
        pass_base = cs_cnt;
        wbase     = wr_cnt;
        drop_slot = drop;
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        check(busy == 1'b1, "R11", "busy after accepted start", int'(busy), 1);
        check(alt_done == 1'b0 && err == 1'b0, "R9", "alt_done/err cleared at start",
              int'({alt_done, err}), 0);
        if (mid_start || mid_alt) begin
            repeat (12) @(negedge clk);
            pass_start = mid_start;
            alt_req    = mid_alt;
            @(negedge clk);
            pass_start = 1'b0;
            alt_req    = 1'b0;
        end
        wait_idle(ok);
        check(ok, "R11", "pass ended", int'(ok), 1);
        check(cs_cnt - pass_base == 4, "R5", "conversions per pass", cs_cnt - pass_base, 4);
        for (int s = 0; s < 4; s++)
            check(int'(seen_sel[(pass_base + s) & 63]) == exp_chan(exp_alt, s),
                  exp_alt ? "R4" : "R3", "slot channel code",
                  int'(seen_sel[(pass_base + s) & 63]), exp_chan(exp_alt, s));
        nwr = (drop >= 0 && drop < 4) ? 3 : 4;
        check(wr_cnt - wbase == nwr, "R10", "writes in pass", wr_cnt - wbase, nwr);
        check(err == (drop >= 0 && drop < 4), "R10", "err flag", int'(err),
              int'(drop >= 0 && drop < 4));
        check(alt_done == exp_alt, "R9", "alt_done after pass", int'(alt_done), int'(exp_alt));
        compare_mem("R6");
        check(tick_miss == 0, "R5", "starts not on tick", tick_miss, 0);
        drop_slot = -1;
    endtask

    bit pend_m = 1'b0;

    initial begin
        int  c0;
        int  w0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 0 && conv_start == 0 && wr_en == 0, "R1", "busy/start/write in reset",
              int'({busy, conv_start, wr_en}), 0);
        check(err == 0 && alt_done == 0 && mux_sel == 0, "R1", "flags and select in reset",
              int'({err, alt_done, mux_sel}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 0, "R2", "idle without pass_start", int'(busy), 0);

        // R3/R6: directed normal passes
        run_pass(1'b0, -1, 1'b0, 1'b0);
        run_pass(1'b0, -1, 1'b0, 1'b0);

        // R8/R4/R9: request while idle applies to next pass only
        @(negedge clk); alt_req = 1'b1; @(negedge clk); alt_req = 1'b0;
        run_pass(1'b1, -1, 1'b0, 1'b0);
        run_pass(1'b0, -1, 1'b0, 1'b0);

        // R8: request during normal pass, applies to following pass
        run_pass(1'b0, -1, 1'b0, 1'b1);
        run_pass(1'b1, -1, 1'b0, 1'b0);

        // R10: filter never answers for slot 2, then for slot 0 of an alternate pass
        run_pass(1'b0, 2, 1'b0, 1'b0);
        @(negedge clk); alt_req = 1'b1; @(negedge clk); alt_req = 1'b0;
        run_pass(1'b1, 0, 1'b0, 1'b0);

        // R2: pass_start during a pass is ignored
        run_pass(1'b0, -1, 1'b1, 1'b0);
        c0 = cs_cnt;
        repeat (60) @(negedge clk);
        check(busy == 0 && cs_cnt == c0, "R2", "no extra pass after mid-pass start",
              cs_cnt - c0, 0);

        // R7: stray filter strobe while idle
        w0 = wr_cnt;
        stray_done = 1'b1; @(negedge clk); stray_done = 1'b0;
        repeat (4) @(negedge clk);
        check(wr_cnt == w0, "R7", "writes from stray strobe", wr_cnt - w0, 0);
        compare_mem("R7");

        // Random mix
        for (int k = 0; k < 30; k++) begin
            int  gap;
            int  drop;
            bit  exp_alt;
            gap = int'($urandom % 20);
            repeat (gap) @(negedge clk);
            if (($urandom % 4) == 0) begin
                alt_req = 1'b1; @(negedge clk); alt_req = 1'b0;
                pend_m = 1'b1;
            end
            drop = (($urandom % 6) == 0) ? int'($urandom % 4) : -1;
            exp_alt = pend_m;
            run_pass(exp_alt, drop, 1'b0, 1'b0);
            if (exp_alt) pend_m = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail + 1);
        $finish;
    end

endmodule